// File: doc/BRIEF.md
# Cartridge Read Bridge to SDRAM

This block sits on a game-cartridge edge connector and serves console CPU word reads from an SDRAM that holds a ROM image. The console's presence line, cartridge chip enable, read strobe and 22-bit word address first pass through two-flop synchronizers into the block clock. A sequencing state machine accepts a read only when all three qualifiers are active. It then asks a small SDRAM sequencer for one word and turns on the 5 V / 3.3 V data transceiver once the word is latched. The word stays on the bus until the console ends the cycle.

The SDRAM address is the console address masked by a ROM-size mask, so a smaller image repeats across the cartridge window. The sequencer clocks the SDRAM at half the block clock. After reset it performs the power-up sequence, and it inserts periodic auto-refresh between console reads. Because the chip enable qualifies every bus drive, the cartridge stays off the data bus while the console runs from its own boot ROM.

Top module: `cart_sdram_bridge`

## Requirements
- R1: The presence, chip-enable, strobe and address inputs act only through two-flop synchronizers. When the strobe rises, xcvr_oe_n_o stays low after the first clk edge and goes high after the second.
- R2: A read is accepted only from idle, with synchronized presence high, cart_ce_n_i low and cart_rd_n_i low, and only after SDRAM initialisation. Without all of these, no SDRAM READ is issued and the transceiver stays disabled.
- R3: After reset the sequencer waits PWR_TICKS SDRAM cycles. It then issues PRECHARGE with A10=1, two AUTO REFRESH and a MODE REGISTER load with address 13'h220 (CAS latency in A[6:4], single-location write A9=1, burst length 1 in A[2:0]=0). No ACTIVE comes before this.
- R4: Each accepted read issues exactly one ACTIVE and one READ. ACTIVE carries bank 0 and row = masked address bits [21:9] on A[12:0]. READ follows at least T_RCD SDRAM cycles later and carries column = masked address bits [8:0] on A[8:0], with A10=1 for auto-precharge.
- R5: The SDRAM word address is {2'b00, cart_addr_i & size_mask_i}. Console addresses that differ only above the mask return the same word.
- R6: The cycle ends and the machine returns to idle once the synchronized strobe is high or presence is low. A fresh qualified read is then accepted.
- R7: xcvr_oe_n_o is high whenever synchronized presence is low, chip enable is high or strobe is high. It is also high until the word of the current read has been latched.
- R8: During a held read, xcvr_oe_n_o is low and cart_data_o carries the value on sdram_dq_i CAS_LAT SDRAM rising edges after the READ. The value is unchanged while the strobe stays low.
- R9: sdram_clk_o has half the frequency of clk. Command, bank and address outputs change only as sdram_clk_o falls and are stable across its rising edge.
- R10: Once initialised, an AUTO REFRESH is issued from idle every REF_TICKS SDRAM cycles.
- R11: An ACTIVE never follows an AUTO REFRESH by fewer than T_RFC SDRAM cycles. A read that arrives during a refresh waits for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cart_present_i | input | 1 | High while a powered console is attached |
| cart_ce_n_i | input | 1 | Cartridge chip enable, active low |
| cart_rd_n_i | input | 1 | Console read strobe, active low |
| cart_addr_i | input | 22 | Console word address |
| size_mask_i | input | 22 | ROM size mask applied to the address |
| cart_data_o | output | 16 | Word presented toward the transceiver |
| xcvr_oe_n_o | output | 1 | Transceiver output enable, active low |
| sdram_clk_o | output | 1 | SDRAM clock, clk divided by two |
| sdram_cke_o | output | 1 | SDRAM clock enable |
| sdram_cs_n_o | output | 1 | SDRAM chip select, active low |
| sdram_ras_n_o | output | 1 | SDRAM row strobe, active low |
| sdram_cas_n_o | output | 1 | SDRAM column strobe, active low |
| sdram_we_n_o | output | 1 | SDRAM write enable, active low |
| sdram_ba_o | output | 2 | SDRAM bank address |
| sdram_addr_o | output | 13 | SDRAM address bus |
| sdram_dq_i | input | 16 | SDRAM read data |

## Verification
The in-line properties check four things on every cycle. A read starts only from qualified inputs. The held word never changes while a read is held. Idle follows a strobe release or presence loss. Commands never change across an SDRAM rising edge. The bench's scenarios show what a property cannot. These are the power-up command order and mode word, mirrored addresses returning identical data, the exact synchronizer lag on the transceiver enable, refresh spacing against reads, and the absence of any bus drive when chip enable or presence is missing.

// File: rtl/cart_bridge_pkg.sv
package cart_bridge_pkg;

  localparam int CART_AW  = 22;
  localparam int DATA_W   = 16;
  localparam int SD_BA_W  = 2;
  localparam int SD_ROW_W = 13;
  localparam int SD_COL_W = 9;
  localparam int SD_A_W   = 13;
  localparam int WORD_AW  = CART_AW + 2;
  localparam int AP_BIT   = 10;

  typedef enum logic [1:0] {BR_IDLE, BR_WAIT, BR_HOLD} br_state_e;

  typedef enum logic [2:0] {
    SQ_PWR, SQ_REFA, SQ_REFB, SQ_MRS, SQ_IDLE, SQ_READ, SQ_LAT
  } sq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = 4'b0111;
  localparam sd_cmd_t CMD_ACT = 4'b0011;
  localparam sd_cmd_t CMD_RD  = 4'b0101;
  localparam sd_cmd_t CMD_PRE = 4'b0010;
  localparam sd_cmd_t CMD_REF = 4'b0001;
  localparam sd_cmd_t CMD_MRS = 4'b0000;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cart_sync.sv
module cart_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= RST_VAL[b];
        sync_q[b] <= RST_VAL[b];
      end else begin
        meta_q[b] <= d_i[b];
        sync_q[b] <= meta_q[b];
      end
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import cart_bridge_pkg::*;
#(
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int PWR_TICKS = 10000,
  parameter int REF_TICKS = 390
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [WORD_AW-1:0] addr_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               sd_clk_o,
  output logic               cke_o,
  output sd_cmd_t            cmd_o,
  output logic [SD_BA_W-1:0] ba_o,
  output logic [SD_A_W-1:0]  a_o,
  input  logic [DATA_W-1:0]  dq_i
);

  localparam int WMAX   = imax(imax(PWR_TICKS, T_RFC), imax(imax(T_RP, T_RCD), imax(T_MRD, CAS_LAT)));
  localparam int WAIT_W = $clog2(WMAX + 1);
  localparam int REF_W  = $clog2(REF_TICKS + 1);

  sq_state_e           st_q, st_d;
  logic [WAIT_W-1:0]   wait_q, wait_d;
  logic [REF_W-1:0]    rcnt_q, rcnt_d;
  logic                due_q, due_d;
  logic                init_q, init_d;
  logic                ph_q;
  logic                cke_q;
  logic                done_q, done_d;
  sd_cmd_t             cmd_q, cmd_d;
  logic [SD_BA_W-1:0]  ba_q, ba_d;
  logic [SD_A_W-1:0]   a_q, a_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                tick;

  logic [SD_COL_W-1:0] col_w;
  logic [SD_ROW_W-1:0] row_w;
  logic [SD_BA_W-1:0]  bank_w;

  assign col_w  = addr_i[SD_COL_W-1:0];
  assign row_w  = addr_i[SD_COL_W +: SD_ROW_W];
  assign bank_w = addr_i[WORD_AW-1 -: SD_BA_W];
  assign tick   = ph_q;

  always_comb begin
    st_d    = st_q;
    wait_d  = wait_q;
    rcnt_d  = rcnt_q;
    due_d   = due_q;
    init_d  = init_q;
    cmd_d   = tick ? CMD_NOP : cmd_q;
    ba_d    = ba_q;
    a_d     = a_q;
    rdata_d = rdata_q;
    done_d  = 1'b0;
    if (tick) begin
      if (wait_q != '0) begin
        wait_d = wait_q - 1'b1;
      end else begin
        unique case (st_q)
          SQ_PWR: begin
            cmd_d          = CMD_PRE;
            a_d            = '0;
            a_d[AP_BIT]    = 1'b1;
            wait_d         = WAIT_W'(T_RP - 1);
            st_d           = SQ_REFA;
          end
          SQ_REFA: begin
            cmd_d  = CMD_REF;
            wait_d = WAIT_W'(T_RFC - 1);
            st_d   = SQ_REFB;
          end
          SQ_REFB: begin
            cmd_d  = CMD_REF;
            wait_d = WAIT_W'(T_RFC - 1);
            st_d   = SQ_MRS;
          end
          SQ_MRS: begin
            cmd_d      = CMD_MRS;
            ba_d       = '0;
            a_d        = '0;
            a_d[6:4]   = 3'(CAS_LAT);
            a_d[9]     = 1'b1;
            wait_d     = WAIT_W'(T_MRD - 1);
            init_d     = 1'b1;
            st_d       = SQ_IDLE;
          end
          SQ_IDLE: begin
            if (due_q) begin
              cmd_d  = CMD_REF;
              wait_d = WAIT_W'(T_RFC - 1);
              due_d  = 1'b0;
            end else if (req_i) begin
              cmd_d  = CMD_ACT;
              ba_d   = bank_w;
              a_d    = SD_A_W'(row_w);
              wait_d = WAIT_W'(T_RCD - 1);
              st_d   = SQ_READ;
            end
          end
          SQ_READ: begin
            cmd_d                 = CMD_RD;
            a_d                   = '0;
            a_d[SD_COL_W-1:0]     = col_w;
            a_d[AP_BIT]           = 1'b1;
            wait_d                = WAIT_W'(CAS_LAT);
            st_d                  = SQ_LAT;
          end
          SQ_LAT: begin
            rdata_d = dq_i;
            done_d  = 1'b1;
            wait_d  = WAIT_W'(T_RP - 1);
            st_d    = SQ_IDLE;
          end
          default: st_d = SQ_PWR;
        endcase
      end
      if (init_q) begin
        if (rcnt_q == REF_W'(REF_TICKS - 1)) begin
          rcnt_d = '0;
          due_d  = 1'b1;
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_PWR;
      wait_q  <= WAIT_W'(PWR_TICKS);
      rcnt_q  <= '0;
      due_q   <= 1'b0;
      init_q  <= 1'b0;
      ph_q    <= 1'b0;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      a_q     <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      wait_q  <= wait_d;
      rcnt_q  <= rcnt_d;
      due_q   <= due_d;
      init_q  <= init_d;
      ph_q    <= ~ph_q;
      cke_q   <= 1'b1;
      done_q  <= done_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      a_q     <= a_d;
      rdata_q <= rdata_d;
    end
  end

  assign ready_o  = init_q;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
  assign sd_clk_o = ph_q;
  assign cke_o    = cke_q;
  assign cmd_o    = cmd_q;
  assign ba_o     = ba_q;
  assign a_o      = a_q;

  // R9
  cmd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q |=> $stable({cmd_q, ba_q, a_q}));

  // R3
  done_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> init_q);

endmodule

// File: rtl/cart_sdram_bridge.sv
module cart_sdram_bridge
  import cart_bridge_pkg::*;
#(
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int PWR_TICKS = 10000,
  parameter int REF_TICKS = 390
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cart_present_i,
  input  logic                cart_ce_n_i,
  input  logic                cart_rd_n_i,
  input  logic [CART_AW-1:0]  cart_addr_i,
  input  logic [CART_AW-1:0]  size_mask_i,
  output logic [DATA_W-1:0]   cart_data_o,
  output logic                xcvr_oe_n_o,
  output logic                sdram_clk_o,
  output logic                sdram_cke_o,
  output logic                sdram_cs_n_o,
  output logic                sdram_ras_n_o,
  output logic                sdram_cas_n_o,
  output logic                sdram_we_n_o,
  output logic [SD_BA_W-1:0]  sdram_ba_o,
  output logic [SD_A_W-1:0]   sdram_addr_o,
  input  logic [DATA_W-1:0]   sdram_dq_i
);

  logic               rst_n_int;
  logic [2:0]         ctl_s;
  logic               pres_s, ce_n_s, rd_n_s;
  logic [CART_AW-1:0] addr_s;
  logic               qual;

  br_state_e          st_q, st_d;
  logic [CART_AW-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d;

  logic               seq_ready, seq_done;
  logic [DATA_W-1:0]  seq_rdata;
  sd_cmd_t            seq_cmd;

  cart_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_int)
  );

  cart_sync #(.W(3), .RST_VAL(3'b011)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n_int),
    .d_i({cart_present_i, cart_ce_n_i, cart_rd_n_i}), .q_o(ctl_s)
  );

  cart_sync #(.W(CART_AW), .RST_VAL('0)) u_addr_sync (
    .clk(clk), .rst_n(rst_n_int), .d_i(cart_addr_i), .q_o(addr_s)
  );

  assign pres_s = ctl_s[2];
  assign ce_n_s = ctl_s[1];
  assign rd_n_s = ctl_s[0];
  assign qual   = pres_s & ~ce_n_s & ~rd_n_s;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    data_d = data_q;
    unique case (st_q)
      BR_IDLE: if (qual && seq_ready) begin
        addr_d = addr_s & size_mask_i;
        st_d   = BR_WAIT;
      end
      BR_WAIT: if (seq_done) begin
        data_d = seq_rdata;
        st_d   = BR_HOLD;
      end
      BR_HOLD: if (rd_n_s || !pres_s) st_d = BR_IDLE;
      default: st_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q   <= BR_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  sdram_rd_seq #(
    .CAS_LAT(CAS_LAT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .PWR_TICKS(PWR_TICKS), .REF_TICKS(REF_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_i    (st_q == BR_WAIT),
    .addr_i   ({2'b00, addr_q}),
    .ready_o  (seq_ready),
    .done_o   (seq_done),
    .rdata_o  (seq_rdata),
    .sd_clk_o (sdram_clk_o),
    .cke_o    (sdram_cke_o),
    .cmd_o    (seq_cmd),
    .ba_o     (sdram_ba_o),
    .a_o      (sdram_addr_o),
    .dq_i     (sdram_dq_i)
  );

  assign sdram_cs_n_o  = seq_cmd.cs_n;
  assign sdram_ras_n_o = seq_cmd.ras_n;
  assign sdram_cas_n_o = seq_cmd.cas_n;
  assign sdram_we_n_o  = seq_cmd.we_n;

  assign cart_data_o = data_q;
  assign xcvr_oe_n_o = ~((st_q == BR_HOLD) & qual);

  // R2
  accept_qual_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_q == BR_WAIT && $past(st_q == BR_IDLE)) |-> $past(qual && seq_ready));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_q == BR_HOLD && $past(st_q == BR_HOLD)) |-> $stable(data_q));

  // R6
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (st_q == BR_HOLD && (rd_n_s || !pres_s)) |=> (st_q == BR_IDLE));

endmodule

// File: tb/tb_cart_sdram_bridge.sv
`timescale 1ns/1ps
module tb_cart_sdram_bridge;

  localparam int CL  = 2;
  localparam int TRP = 2;
  localparam int TRCD = 2;
  localparam int TRFC = 6;
  localparam int TMRD = 2;
  localparam int PWR = 50;
  localparam int REFT = 100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        present, ce_n, rd_n;
  logic [21:0] addr, mask;
  logic [15:0] data;
  logic        oe_n;
  logic        sclk, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] sa;
  logic [15:0] dq;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cart_sdram_bridge #(
    .CAS_LAT(CL), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC),
    .T_MRD(TMRD), .PWR_TICKS(PWR), .REF_TICKS(REFT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cart_present_i(present), .cart_ce_n_i(ce_n),
    .cart_rd_n_i(rd_n), .cart_addr_i(addr), .size_mask_i(mask),
    .cart_data_o(data), .xcvr_oe_n_o(oe_n), .sdram_clk_o(sclk),
    .sdram_cke_o(cke), .sdram_cs_n_o(cs_n), .sdram_ras_n_o(ras_n),
    .sdram_cas_n_o(cas_n), .sdram_we_n_o(we_n), .sdram_ba_o(ba),
    .sdram_addr_o(sa), .sdram_dq_i(dq)
  );

  function automatic logic [15:0] mem_word(input logic [12:0] row, input logic [8:0] col);
    return ({3'b0, row} * 16'd37) ^ ({7'b0, col} * 16'd5) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] exp_word(input logic [21:0] a, input logic [21:0] m);
    logic [21:0] x;
    x = a & m;
    return mem_word(x[21:9], x[8:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // SDRAM model
  int        rise_n = 0, last_ref = -1000, last_act = -1000;
  int        n_read = 0, n_ref = 0, n_mrs = 0, log_n = 0;
  int        ref_viol = 0, rcd_viol = 0, per_viol = 0, pend = 0;
  logic [3:0]  cmd_log [0:4];
  logic [12:0] act_row, mrs_a;
  logic [1:0]  act_ba;
  logic [8:0]  rd_col;
  logic        rd_a10, pre_a10;
  logic [15:0] pend_word;
  realtime     last_rise = 0.0;

  initial dq = 16'h0000;

  always @(posedge sclk) begin
    logic [3:0] c;
    rise_n++;
    if (rise_n > 1 && ($realtime - last_rise) != 10.0) per_viol++;
    last_rise = $realtime;
    if (pend > 0) begin
      pend--;
      if (pend == 0) dq <= pend_word;
    end
    c = {cs_n, ras_n, cas_n, we_n};
    if (c != 4'b0111 && log_n < 5) begin
      cmd_log[log_n] = c;
      log_n++;
    end
    case (c)
      4'b0011: begin
        if (rise_n - last_ref < TRFC) ref_viol++;
        act_row = sa; act_ba = ba; last_act = rise_n;
      end
      4'b0101: begin
        if (rise_n - last_act < TRCD) rcd_viol++;
        rd_col = sa[8:0]; rd_a10 = sa[10]; n_read++;
        pend_word = mem_word(act_row, sa[8:0]); pend = CL;
        dq <= 16'hBAD0;
      end
      4'b0001: begin n_ref++; last_ref = rise_n; end
      4'b0000: begin n_mrs++; mrs_a = sa; end
      4'b0010: pre_a10 = sa[10];
      default: ;
    endcase
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  task automatic wait_oe(output bit got);
    got = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!oe_n) begin got = 1; break; end
    end
  endtask

  // Performs one full console read and checks it
  task automatic do_read(input logic [21:0] a, input logic [21:0] m, input int hold);
    int r0;
    bit got;
    logic [21:0] x;
    logic [15:0] e;
    x = a & m;
    e = exp_word(a, m);
    r0 = n_read;
    @(negedge clk);
    mask = m; addr = a; present = 1'b1; ce_n = 1'b0; rd_n = 1'b0;
    wait_oe(got);
    chk(got, "R8 transceiver enabled", {31'b0, oe_n}, 32'h0);
    chk(data == e, "R5 R8 word", {16'b0, data}, {16'b0, e});
    chk(act_row == x[21:9] && act_ba == 2'b00, "R4 R5 row/bank", {17'b0, act_ba, act_row}, {19'b0, x[21:9]});
    chk(rd_col == x[8:0] && rd_a10, "R4 column/auto-precharge", {22'b0, rd_a10, rd_col}, {22'b0, 1'b1, x[8:0]});
    repeat (hold) @(negedge clk);
    chk(!oe_n && data == e, "R8 hold stable", {15'b0, oe_n, data}, {16'b0, e});
    rd_n = 1'b1;
    @(negedge clk);
    chk(!oe_n, "R1 synchronizer lag", {31'b0, oe_n}, 32'h0);
    @(negedge clk);
    chk(oe_n, "R7 strobe high disables", {31'b0, oe_n}, 32'h1);
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(n_read - r0 == 1, "R4 one READ per access", n_read - r0, 1);
  endtask

  initial begin
    bit got;
    int r0, f0;
    logic [15:0] e1, e2;
    rst_n = 1'b0;
    present = 1'b1; ce_n = 1'b0; rd_n = 1'b0;
    addr = 22'h12345; mask = 22'h3FFFFF;
    repeat (5) @(negedge clk);
    chk(oe_n, "R7 reset state", {31'b0, oe_n}, 32'h1);
    chk(data == 16'h0, "R8 reset data", {16'b0, data}, 32'h0);
    rst_n = 1'b1;

    // read held from before init: must wait for power-up sequence
    wait_oe(got);
    chk(got, "R2 read after init", {31'b0, oe_n}, 32'h0);
    chk(log_n == 5, "R3 command count", log_n, 5);
    chk(cmd_log[0] == 4'b0010 && pre_a10, "R3 precharge-all first", {27'b0, pre_a10, cmd_log[0]}, 32'h12);
    chk(cmd_log[1] == 4'b0001 && cmd_log[2] == 4'b0001, "R3 two refreshes", {24'b0, cmd_log[1], cmd_log[2]}, 32'h11);
    chk(cmd_log[3] == 4'b0000 && mrs_a == 13'h220, "R3 mode word", {15'b0, cmd_log[3], mrs_a}, 32'h0220);
    chk(cmd_log[4] == 4'b0011, "R3 R4 first ACT after init", {28'b0, cmd_log[4]}, 32'h3);
    chk(data == exp_word(22'h12345, 22'h3FFFFF), "R8 first word", {16'b0, data}, {16'b0, exp_word(22'h12345, 22'h3FFFFF)});
    @(negedge clk); rd_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);

    // mirroring
    do_read(22'h3C1234, 22'h03FFFF, 3);
    e1 = data;
    do_read(22'h001234, 22'h03FFFF, 0);
    e2 = data;
    chk(e1 == e2, "R5 mirrored image", {16'b0, e1}, {16'b0, e2});
    do_read(22'h3FFFFF, 22'h3FFFFF, 2);
    do_read(22'h000000, 22'h0FFFFF, 1);

    // chip enable high: no bus drive, no SDRAM read
    r0 = n_read;
    @(negedge clk); present = 1'b1; ce_n = 1'b1; rd_n = 1'b0;
    got = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (!oe_n) got = 1; end
    chk(!got && n_read == r0, "R2 chip enable high ignored", n_read - r0, 0);
    @(negedge clk); present = 1'b0; ce_n = 1'b0;
    got = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (!oe_n) got = 1; end
    chk(!got && n_read == r0, "R2 absent console ignored", n_read - r0, 0);
    @(negedge clk); rd_n = 1'b1; ce_n = 1'b1;

    // chip enable toggled during a held read
    @(negedge clk); mask = 22'h3FFFFF; addr = 22'h2ABCDE; present = 1'b1; ce_n = 1'b0; rd_n = 1'b0;
    wait_oe(got);
    e1 = exp_word(22'h2ABCDE, 22'h3FFFFF);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(oe_n, "R7 chip enable high disables", {31'b0, oe_n}, 32'h1);
    ce_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!oe_n && data == e1, "R8 word held across enable gap", {15'b0, oe_n, data}, {16'b0, e1});

    // presence loss ends cycle, then a new read is accepted
    r0 = n_read;
    present = 1'b0;
    repeat (3) @(negedge clk);
    chk(oe_n, "R6 R7 presence loss", {31'b0, oe_n}, 32'h1);
    addr = 22'h054321; present = 1'b1;
    wait_oe(got);
    chk(got && n_read == r0 + 1 && data == exp_word(22'h054321, 22'h3FFFFF), "R6 new read after presence loss",
        {16'b0, data}, {16'b0, exp_word(22'h054321, 22'h3FFFFF)});
    @(negedge clk); rd_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);

    // refresh while idle
    f0 = n_ref;
    repeat (1000) @(negedge clk);
    chk(n_ref - f0 >= 4 && n_ref - f0 <= 6, "R10 refresh rate", n_ref - f0, 5);

    // random reads with fixed seed
    void'($urandom(32'h5EED));
    for (int k = 0; k < 50; k++) begin
      logic [21:0] ra, rm;
      ra = 22'($urandom);
      case ($urandom % 4)
        0: rm = 22'h03FFFF;
        1: rm = 22'h0FFFFF;
        2: rm = 22'h01FFFF;
        default: rm = 22'h3FFFFF;
      endcase
      do_read(ra, rm, int'($urandom % 20));
      repeat (int'($urandom % 30)) @(negedge clk);
    end

    chk(ref_viol == 0, "R11 refresh to ACT spacing", ref_viol, 0);
    chk(rcd_viol == 0, "R4 ACT to READ spacing", rcd_viol, 0);
    chk(per_viol == 0 && rise_n > 100, "R9 half-rate SDRAM clock", per_viol, 0);
    chk(cke, "R3 clock enable high", {31'b0, cke}, 32'h1);
    summary();
  end

endmodule